// File: doc/BRIEF.md
# Interrupt Concentrator with Mapping Registers

The block gathers 64 level-sensitive interrupt lines and presents at most one interrupt request to the CPU at a time. The request is an interrupt number plus a valid flag. Lines 0 to 31 come from PCI slots and lines 32 to 63 come from onboard I/O devices. PCI lines share one mapping register per group of four lines. Each onboard line has its own mapping register. Only the top bit of a mapping register, the enable, can be written.

Software enables lines through the mapping registers and retires the current request through clear registers. Both sit behind a simple word-addressed register port. When a request is retired, the block chooses the next one, scanning from the lowest eligible line upward. Once issued, a request is held until software retires it, even if lower-numbered lines assert or the line itself drops.

A small combinational helper converts a PCI slot, a function parity bit and an interrupt pin into the line index that the slot drives.

Top module: `irq_concentrator`

## Requirements
- R1: Line i (0 to 31) is enabled by PCI mapping register i/4. Line i (32 to 63) is enabled by onboard mapping register i-32.
- R2: A mapping register reads as {enable, payload} with the enable in bit 31. The PCI payload of register g is 0x7C0 + 4g and the onboard payload of register k is 0x7E0 + k. A write sets only bit 31, taken from reg_wbit.
- R3: Byte address layout (reg_addr carries bits 9:2). PCI mapping register g is at 0x000+8g+4 and onboard mapping register k is at 0x100+8k+4. The PCI clear register g is at 0x200+8g+4 and the onboard clear register k is at 0x300+8k+4. Locations with address bit 2 = 0 read as 0, and writes to them have no effect. Clear registers read as 0.
- R4: At most one request is outstanding. While it is pending, req_num stays unchanged, even when lower lines assert or the pending line deasserts, until the request is cleared.
- R5: With nothing pending, the lowest-index line that is both asserted and enabled is issued. Lines are sampled at a clock edge, and the request becomes visible after the following edge.
- R6: Writing 0 to the enable that owns the pending request clears that request.
- R7: A write to PCI clear register g clears a pending request whose number is below 32 and has number/4 = g. A write that does not match leaves the request unchanged.
- R8: A write to onboard clear register k clears a pending request numbered 32+k. A write that does not match leaves the request unchanged.
- R9: In the same cycle as a clear, the lines are re-evaluated, so another eligible line, or the same line if it is still eligible, is issued on the same edge.
- R10: Reset (rst_n low) clears all enables, the pending request and the sampled lines. Payloads are unaffected.
- R11: map_line = (16 if map_func0 else 0) + 4*map_slot + map_pin, modulo 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 64 | Level interrupt lines |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Byte address bits 9:2 |
| reg_wbit | input | 1 | Write data bit 31 (enable) |
| reg_rdata | output | 32 | Combinational read data |
| req_valid | output | 1 | Request outstanding |
| req_num | output | 6 | Number of the outstanding request |
| map_slot | input | 3 | Slot number (low bits; higher bits vanish modulo 32) |
| map_func0 | input | 1 | Function number bit 0 |
| map_pin | input | 2 | Interrupt pin, 0 to 3 |
| map_line | output | 5 | Resulting PCI line index |

## Verification
A clear, by disable or by clear register, and the selection of the next request fall on the same clock edge. The bench provokes this in two ways. It retires a request while other enabled lines are asserted and expects the next-lowest line straight away. It also disables a group whose line is pending while an onboard line waits and expects the onboard number on that edge. A reference model in the bench applies the register write first and then picks the next request from the updated enables. It is compared every cycle, both in these directed cases and under random mixes of line activity and register writes.

// File: rtl/irq_concentrator.sv
module irq_concentrator (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [63:0] irq_in,
  input  logic        reg_we,
  input  logic [9:2]  reg_addr,
  input  logic        reg_wbit,
  output logic [31:0] reg_rdata,
  output logic        req_valid,
  output logic [5:0]  req_num,
  input  logic [2:0]  map_slot,
  input  logic        map_func0,
  input  logic [1:0]  map_pin,
  output logic [4:0]  map_line
);

  logic [63:0] lvl_q;
  logic [7:0]  pci_en, pci_en_n;
  logic [31:0] ob_en, ob_en_n;
  logic        pend;
  logic [63:0] elig;
  logic        found;
  logic [5:0]  pick;

  wire       odd   = reg_addr[2];
  wire [1:0] rgn   = reg_addr[9:8];
  wire [2:0] grp   = reg_addr[5:3];
  wire [4:0] obi   = reg_addr[7:3];
  wire       pci_w = (reg_addr[7:6] == 2'b00);

  wire sel_pci_map = odd && rgn == 2'd0 && pci_w;
  wire sel_ob_map  = odd && rgn == 2'd1;
  wire sel_pci_clr = odd && rgn == 2'd2 && pci_w;
  wire sel_ob_clr  = odd && rgn == 2'd3;

  always_comb begin
    pci_en_n = pci_en;
    ob_en_n  = ob_en;
    if (reg_we && sel_pci_map) pci_en_n[grp] = reg_wbit;
    if (reg_we && sel_ob_map)  ob_en_n[obi]  = reg_wbit;
  end

  wire own_en   = req_num[5] ? ob_en[req_num[4:0]]   : pci_en[req_num[4:2]];
  wire own_en_n = req_num[5] ? ob_en_n[req_num[4:0]] : pci_en_n[req_num[4:2]];
  wire dis_hit  = pend && !own_en_n;
  wire clr_hit  = pend && reg_we &&
                  ((sel_pci_clr && !req_num[5] && req_num[4:2] == grp) ||
                   (sel_ob_clr  &&  req_num[5] && req_num[4:0] == obi));
  wire drop     = dis_hit || clr_hit;

  always_comb begin
    for (int i = 0; i < 32; i++) begin
      elig[i]      = lvl_q[i]      && pci_en_n[i >> 2];
      elig[32 + i] = lvl_q[32 + i] && ob_en_n[i];
    end
    pick = '0;
    for (int i = 63; i >= 0; i--)
      if (elig[i]) pick = 6'(i);
  end
  assign found = |elig;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl_q   <= '0;
      pci_en  <= '0;
      ob_en   <= '0;
      pend    <= 1'b0;
      req_num <= '0;
    end else begin
      lvl_q  <= irq_in;
      pci_en <= pci_en_n;
      ob_en  <= ob_en_n;
      if (!pend || drop) begin
        pend <= found;
        if (found) req_num <= pick;
      end
    end
  end

  assign req_valid = pend;

  always_comb begin
    reg_rdata = '0;
    if (sel_pci_map) reg_rdata = {pci_en[grp], 31'h7C0 | 31'({grp, 2'b00})};
    if (sel_ob_map)  reg_rdata = {ob_en[obi],  31'(32'h7E0 + 32'(obi))};
  end

  assign map_line = {map_func0, 4'b0000} + {map_slot, 2'b00} + {3'b000, map_pin};

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !drop) |=> (req_valid && $stable(req_num)));

  assert_issue_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend && found) |=> req_valid);

  assert_owner_enabled_R6: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> own_en);

  assert_disable_moves_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dis_hit |=> (!req_valid || req_num != $past(req_num)));

  assert_even_word_inert_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && !odd) |=> ($stable(pci_en) && $stable(ob_en)));

endmodule

// File: tb/tb_irq_concentrator.sv
module tb_irq_concentrator;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_n = 0;
  logic [63:0] irq = '0;
  logic        we = 0, wbit = 0;
  logic [9:0]  addr = '0;
  logic [31:0] rdata;
  logic        req_valid;
  logic [5:0]  req_num;
  logic [2:0]  slot = 0;
  logic        func0 = 0;
  logic [1:0]  pin = 0;
  logic [4:0]  line;

  int n_chk = 0, n_bad = 0;

  logic [63:0] m_lvl;
  logic [7:0]  m_pen;
  logic [31:0] m_oen;
  logic        m_pend;
  int          m_num;

  always #(CLK_PERIOD / 2) clk = ~clk;

  irq_concentrator dut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq), .reg_we(we), .reg_addr(addr[9:2]),
    .reg_wbit(wbit), .reg_rdata(rdata), .req_valid(req_valid), .req_num(req_num),
    .map_slot(slot), .map_func0(func0), .map_pin(pin), .map_line(line));

  function automatic logic m_enabled(int i, logic [7:0] pe, logic [31:0] oe);
    return (i < 32) ? pe[i / 4] : oe[i - 32];
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic model_update();
    logic [7:0]  np = m_pen;
    logic [31:0] no = m_oen;
    logic        drop = 0;
    if (we && addr[2]) begin
      if (addr[9:8] == 0 && addr[7:6] == 0) np[addr[5:3]] = wbit;
      if (addr[9:8] == 1) no[addr[7:3]] = wbit;
    end
    if (m_pend) begin
      if (!m_enabled(m_num, np, no)) drop = 1;
      if (we && addr[2] && addr[9:8] == 2 && addr[7:6] == 0 && m_num < 32 && m_num / 4 == int'(addr[5:3])) drop = 1;
      if (we && addr[2] && addr[9:8] == 3 && m_num >= 32 && m_num - 32 == int'(addr[7:3])) drop = 1;
    end
    if (!m_pend || drop) begin
      m_pend = 0;
      for (int i = 0; i < 64; i++)
        if (m_lvl[i] && m_enabled(i, np, no)) begin
          m_pend = 1; m_num = i; break;
        end
    end
    m_lvl = irq; m_pen = np; m_oen = no;
  endtask

  task automatic step(logic w, logic [9:0] a, logic b);
    we = w; addr = a; wbit = b;
    @(posedge clk);
    model_update();
    @(negedge clk);
    we = 0;
    chk("R4/R5 model valid", 32'(req_valid), 32'(m_pend));
    if (m_pend) chk("R4/R5 model num", 32'(req_num), 32'(m_num));
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) step(0, 10'h000, 0);
  endtask

  task automatic rd(logic [9:0] a, logic [31:0] exp, string tag);
    we = 0; addr = a; #1;
    chk(tag, rdata, exp);
  endtask

  task automatic do_reset();
    rst_n = 0; irq = '0;
    @(posedge clk); @(posedge clk);
    m_lvl = '0; m_pen = '0; m_oen = '0; m_pend = 0; m_num = 0;
    @(negedge clk); rst_n = 1;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    do_reset();
    chk("R10 reset valid", 32'(req_valid), 0);
    rd(10'h01C, 32'h0000_07CC, "R2 pci payload g3");
    rd(10'h12C, 32'h0000_07E5, "R2 onboard payload k5");
    rd(10'h018, 32'h0, "R3 even word reads 0");
    rd(10'h20C, 32'h0, "R3 clear reads 0");

    step(1, 10'h00C, 1);
    rd(10'h00C, 32'h8000_07C4, "R2 enable write g1");
    step(1, 10'h010, 1);
    rd(10'h014, 32'h0000_07C8, "R3 even write ignored");

    irq = 64'h0000_0100_0000_0060;
    idle(2);
    chk("R5 lowest eligible", 32'(req_num), 5);
    chk("R1 onboard 40 not enabled", 32'(req_valid), 1);
    irq[4] = 1; idle(2);
    chk("R4 hold vs lower line", 32'(req_num), 5);
    irq[5] = 0; idle(2);
    chk("R4 hold after deassert", 32'(req_num), 5);
    step(1, 10'h204, 1);
    chk("R7 mismatched clear ignored", 32'(req_num), 5);
    step(1, 10'h20C, 1);
    chk("R9 repick after pci clear", 32'(req_num), 4);
    step(1, 10'h144, 1);
    rd(10'h144, 32'h8000_07E8, "R2 onboard enable k8");
    step(1, 10'h00C, 0);
    chk("R6 disable clears, R9 repick", 32'(req_num), 40);
    step(1, 10'h30C, 1);
    chk("R8 mismatched onboard clear", 32'(req_num), 40);
    irq[40] = 0; idle(1);
    chk("R4 held after drop", 32'(req_valid), 1);
    step(1, 10'h344, 1);
    chk("R8 onboard clear", 32'(req_valid), 0);

    slot = 3; func0 = 0; pin = 2; #1;
    chk("R11 slot3 pin2", 32'(line), 14);
    slot = 5; func0 = 1; pin = 3; #1;
    chk("R11 wrap", 32'(line), 7);
    slot = 7; func0 = 1; pin = 3; #1;
    chk("R11 max", 32'(line), 15);

    for (int n = 0; n < 4000; n++) begin
      logic [9:0] a;
      if ($urandom_range(0, 7) == 0) irq[$urandom_range(0, 63)] = ~irq[$urandom_range(0, 63)];
      if ($urandom_range(0, 5) == 0) irq[$urandom_range(0, 63)] ^= 1'b1;
      a = 10'($urandom_range(0, 1023)) & 10'h3FC;
      if ($urandom_range(0, 3) != 0 && (a[9:8] == 0 || a[9:8] == 2)) a[7:6] = 0;
      if ($urandom_range(0, 3) != 0) a[2] = 1;
      step($urandom_range(0, 2) == 0, a, 1'($urandom_range(0, 3) != 0));
    end

    irq = '1; step(1, 10'h00C, 1); idle(2);
    do_reset();
    chk("R10 reset clears request", 32'(req_valid), 0);
    rd(10'h00C, 32'h0000_07C4, "R10 reset clears enable");
    idle(3);
    chk("R10 no request without enables", 32'(req_valid), 0);
    finish_run();
  end
endmodule